// File: doc/BRIEF.md
# Host-to-Engine Message Unit

This unit carries short messages between a host processor and an embedded engine. The host sees a small register window. One data address serves both directions: a write to it pushes a word into the inbound queue, and a read from it pops a word from the outbound queue. A status word shows the fill state of both queues, and a control word enables the interrupts and gates access to the queues. A message is two 32-bit words. The host sends a message only while the inbound queue is empty. The exchange is complete once the engine has drained both words.

The engine drains the inbound queue and fills the outbound queue through valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. The unit never stalls the host. A push that finds its queue full is dropped, and a pop that finds its queue empty returns zero. Back-pressure therefore reaches the engine only through `eng_out_ready` and `eng_wp_ready`. The engine can also post a word to a mailbox, which the host clears by writing a fixed pattern. A small watch queue lets the engine post 31-bit words that the host drains by reading until bit 31 comes back clear.

Host reads are registered. `host_rdata` shows the addressed register one cycle after `host_rd` and holds that value until the next read. The register addresses are: 0 data, 1 status, 2 control, 3 mailbox, 4 watch.

Top module: `hmu_top`

## Requirements
- R1: After reset, status reads 0x00060000, control and mailbox read 0, and all four interrupt pins and `eng_in_valid` are low.
- R2: A host write to address 0 pushes the word into the inbound queue only while control bit 25 is set. The engine receives the words in order on `eng_in_valid`/`eng_in_data` and pops one with `eng_in_ready`.
- R3: The inbound queue holds 2 words. A host push while it is full is dropped.
- R4: `eng_out_ready` is high only while control bit 24 is set and the outbound queue holds fewer than 2 words. Host reads of address 0 return the engine's words in push order.
- R5: A host read of address 0 while the outbound queue is empty returns 0 and changes no state.
- R6: The status bits are: 16 outbound not empty, 17 inbound not full, 18 outbound not full, 19 inbound not empty, 20 mailbox interrupt, 21 inbound interrupt, 22 outbound interrupt, 23 watch interrupt. All other bits read 0.
- R7: The inbound interrupt (`irq_in`, status bit 21) equals control bit 17 AND inbound empty. The outbound interrupt (`irq_out`, status bit 22) equals control bit 16 AND outbound not empty.
- R8: An engine mailbox write stores its word and raises `irq_mbx` (status bit 20). A host write of 0x0000F0F0 to address 3 clears the stored word to 0 and drops `irq_mbx`. Any other host value written there has no effect. If both happen in the same cycle, the engine write takes priority.
- R9: A host read of address 4 pops the watch queue (4 deep) and returns bit 31 = 1 with the word in bits 30:0. When the queue is empty it returns 0. `irq_wp` (status bit 23) is high while the queue is not empty.
- R10: Control stores only bits 16, 17, 24 and 25. All other bits read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| eng_in_valid | output | 1 | Inbound head word available |
| eng_in_ready | input | 1 | Engine pops inbound head |
| eng_in_data | output | 32 | Inbound head word |
| eng_out_valid | input | 1 | Engine offers an outbound word |
| eng_out_ready | output | 1 | Outbound queue accepts |
| eng_out_data | input | 32 | Outbound word |
| eng_mbx_wr | input | 1 | Engine mailbox write |
| eng_mbx_data | input | 32 | Engine mailbox word |
| eng_wp_valid | input | 1 | Engine offers a watch word |
| eng_wp_ready | output | 1 | Watch queue accepts |
| eng_wp_data | input | 31 | Watch word |
| irq_mbx | output | 1 | Mailbox interrupt |
| irq_in | output | 1 | Inbound interrupt |
| irq_out | output | 1 | Outbound interrupt |
| irq_wp | output | 1 | Watch interrupt |

## Verification
On every cycle, the assertions check four things: the queue occupancy stays within its depth, `eng_out_ready` is low whenever the outbound queue is full, an interrupt pin is never high while its queue condition is false, and a read of an empty data port returns zero. They also check that the mailbox clear pattern drops `irq_mbx` when the engine is not writing. Only the bench scenarios can show ordering and content. These cover words leaving each queue in push order, the dropped third word of a full inbound queue, the gating by control bits 24 and 25, the mailbox priority on a same-cycle write, and the exact status words across fill states.

// File: rtl/hmu_pkg.sv
package hmu_pkg;
  localparam int REG_W = 32;
  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADR_W-1:0] A_CTRL  = 3'd2;
  localparam logic [ADR_W-1:0] A_MBX   = 3'd3;
  localparam logic [ADR_W-1:0] A_WATCH = 3'd4;

  // status bit positions
  localparam int S_OUT_NE  = 16;
  localparam int S_IN_NF   = 17;
  localparam int S_OUT_NF  = 18;
  localparam int S_IN_NE   = 19;
  localparam int S_MBX_IRQ = 20;
  localparam int S_IN_IRQ  = 21;
  localparam int S_OUT_IRQ = 22;
  localparam int S_WP_IRQ  = 23;

  // control bit positions
  localparam int C_OUT_IE  = 16;
  localparam int C_IN_IE   = 17;
  localparam int C_OUT_ACC = 24;
  localparam int C_IN_ACC  = 25;

  localparam logic [REG_W-1:0] MBX_CLEAR = 32'h0000_F0F0;

  typedef struct packed {
    logic out_ie;
    logic in_ie;
    logic out_acc;
    logic in_acc;
  } ctl_t;
endpackage

// File: rtl/hmu_fifo.sv
module hmu_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end
endmodule

// File: rtl/hmu_mbox.sv
module hmu_mbox
  import hmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_clr_wr,
  input  logic [REG_W-1:0] host_val,
  input  logic             eng_wr,
  input  logic [REG_W-1:0] eng_val,
  output logic [REG_W-1:0] word,
  output logic             pending
);
  logic clr_hit;
  assign clr_hit = host_clr_wr && (host_val == MBX_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word    <= '0;
      pending <= 1'b0;
    end else if (eng_wr) begin
      word    <= eng_val;
      pending <= 1'b1;
    end else if (clr_hit) begin
      word    <= '0;
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/hmu_flags.sv
module hmu_flags
  import hmu_pkg::*;
(
  input  ctl_t             ctl,
  input  logic             in_empty,
  input  logic             in_full,
  input  logic             out_empty,
  input  logic             out_full,
  input  logic             mbx_pend,
  input  logic             wp_empty,
  output logic [REG_W-1:0] status,
  output logic             irq_mbx,
  output logic             irq_in,
  output logic             irq_out,
  output logic             irq_wp
);
  assign irq_in  = ctl.in_ie && in_empty;
  assign irq_out = ctl.out_ie && !out_empty;
  assign irq_mbx = mbx_pend;
  assign irq_wp  = !wp_empty;

  always_comb begin
    status            = '0;
    status[S_OUT_NE]  = !out_empty;
    status[S_IN_NF]   = !in_full;
    status[S_OUT_NF]  = !out_full;
    status[S_IN_NE]   = !in_empty;
    status[S_MBX_IRQ] = irq_mbx;
    status[S_IN_IRQ]  = irq_in;
    status[S_OUT_IRQ] = irq_out;
    status[S_WP_IRQ]  = irq_wp;
  end
endmodule

// File: rtl/hmu_top.sv
module hmu_top
  import hmu_pkg::*;
#(
  parameter int IN_DEPTH  = 2,
  parameter int OUT_DEPTH = 2,
  parameter int WP_DEPTH  = 4,
  localparam int ICW = $clog2(IN_DEPTH + 1),
  localparam int OCW = $clog2(OUT_DEPTH + 1),
  localparam int WCW = $clog2(WP_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [ADR_W-1:0] host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  output logic             eng_in_valid,
  input  logic             eng_in_ready,
  output logic [REG_W-1:0] eng_in_data,
  input  logic             eng_out_valid,
  output logic             eng_out_ready,
  input  logic [REG_W-1:0] eng_out_data,
  input  logic             eng_mbx_wr,
  input  logic [REG_W-1:0] eng_mbx_data,
  input  logic             eng_wp_valid,
  output logic             eng_wp_ready,
  input  logic [REG_W-2:0] eng_wp_data,
  output logic             irq_mbx,
  output logic             irq_in,
  output logic             irq_out,
  output logic             irq_wp
);
  ctl_t ctl_q;
  logic [ICW-1:0] in_cnt;
  logic [OCW-1:0] out_cnt;
  logic [WCW-1:0] wp_cnt;
  logic in_empty, in_full, out_empty, out_full, wp_empty, wp_full;
  logic [REG_W-1:0] out_head, status, mbx_word;
  logic [REG_W-2:0] wp_head;
  logic mbx_pend;

  logic wr_data, rd_data, rd_watch;
  assign wr_data  = host_wr && (host_addr == A_DATA);
  assign rd_data  = host_rd && (host_addr == A_DATA);
  assign rd_watch = host_rd && (host_addr == A_WATCH);

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else if (host_wr && host_addr == A_CTRL) begin
      ctl_q.out_ie  <= host_wdata[C_OUT_IE];
      ctl_q.in_ie   <= host_wdata[C_IN_IE];
      ctl_q.out_acc <= host_wdata[C_OUT_ACC];
      ctl_q.in_acc  <= host_wdata[C_IN_ACC];
    end
  end

  hmu_fifo #(.DW(REG_W), .DEPTH(IN_DEPTH)) u_in (
    .clk, .rst_n,
    .push(wr_data && ctl_q.in_acc), .push_data(host_wdata),
    .pop(eng_in_ready), .head(eng_in_data),
    .count(in_cnt), .empty(in_empty), .full(in_full)
  );
  assign eng_in_valid = !in_empty;

  hmu_fifo #(.DW(REG_W), .DEPTH(OUT_DEPTH)) u_out (
    .clk, .rst_n,
    .push(eng_out_valid && eng_out_ready), .push_data(eng_out_data),
    .pop(rd_data), .head(out_head),
    .count(out_cnt), .empty(out_empty), .full(out_full)
  );
  assign eng_out_ready = ctl_q.out_acc && !out_full;

  hmu_fifo #(.DW(REG_W-1), .DEPTH(WP_DEPTH)) u_wp (
    .clk, .rst_n,
    .push(eng_wp_valid), .push_data(eng_wp_data),
    .pop(rd_watch), .head(wp_head),
    .count(wp_cnt), .empty(wp_empty), .full(wp_full)
  );
  assign eng_wp_ready = !wp_full;

  hmu_mbox u_mbx (
    .clk, .rst_n,
    .host_clr_wr(host_wr && host_addr == A_MBX), .host_val(host_wdata),
    .eng_wr(eng_mbx_wr), .eng_val(eng_mbx_data),
    .word(mbx_word), .pending(mbx_pend)
  );

  hmu_flags u_flags (
    .ctl(ctl_q), .in_empty, .in_full, .out_empty, .out_full,
    .mbx_pend, .wp_empty, .status,
    .irq_mbx, .irq_in, .irq_out, .irq_wp
  );

  logic [REG_W-1:0] ctl_word;
  always_comb begin
    ctl_word            = '0;
    ctl_word[C_OUT_IE]  = ctl_q.out_ie;
    ctl_word[C_IN_IE]   = ctl_q.in_ie;
    ctl_word[C_OUT_ACC] = ctl_q.out_acc;
    ctl_word[C_IN_ACC]  = ctl_q.in_acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) begin
      case (host_addr)
        A_DATA:  host_rdata <= out_empty ? '0 : out_head;
        A_STAT:  host_rdata <= status;
        A_CTRL:  host_rdata <= ctl_word;
        A_MBX:   host_rdata <= mbx_word;
        A_WATCH: host_rdata <= wp_empty ? '0 : {1'b1, wp_head};
        default: host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/hmu_chk.sv
module hmu_chk
  import hmu_pkg::*;
#(
  parameter int IN_DEPTH  = 2,
  parameter int OUT_DEPTH = 2,
  parameter int ICW = 2,
  parameter int OCW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic [ADR_W-1:0] host_addr,
  input logic [REG_W-1:0] host_wdata,
  input logic [REG_W-1:0] host_rdata,
  input logic             eng_out_ready,
  input logic             eng_mbx_wr,
  input logic             irq_mbx,
  input logic             irq_in,
  input logic             irq_out,
  input logic [ICW-1:0]   in_cnt,
  input logic [OCW-1:0]   out_cnt
);
  AST_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= ICW'(IN_DEPTH)); // R3
  AST_OUT_FULL_NORDY: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt == OCW'(OUT_DEPTH) |-> !eng_out_ready); // R4
  AST_EMPTY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_DATA && out_cnt == '0) |=> host_rdata == '0); // R5
  AST_IN_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |-> in_cnt == '0); // R7
  AST_OUT_IRQ_NE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> out_cnt != '0); // R7
  AST_MBX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_MBX && host_wdata == MBX_CLEAR && !eng_mbx_wr)
      |=> !irq_mbx); // R8
endmodule

bind hmu_top hmu_chk #(
  .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .ICW(ICW), .OCW(OCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .eng_out_ready(eng_out_ready), .eng_mbx_wr(eng_mbx_wr),
  .irq_mbx(irq_mbx), .irq_in(irq_in), .irq_out(irq_out),
  .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/hmu_top_tb.sv
module hmu_top_tb;
  import hmu_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic eng_in_valid, eng_in_ready = 0;
  logic [31:0] eng_in_data;
  logic eng_out_valid = 0, eng_out_ready;
  logic [31:0] eng_out_data = '0;
  logic eng_mbx_wr = 0;
  logic [31:0] eng_mbx_data = '0;
  logic eng_wp_valid = 0, eng_wp_ready;
  logic [30:0] eng_wp_data = '0;
  logic irq_mbx, irq_in, irq_out, irq_wp;

  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  hmu_top u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic epush(input logic [31:0] d, output logic rdy);
    @(negedge clk); eng_out_valid = 1; eng_out_data = d; rdy = eng_out_ready;
    @(negedge clk); eng_out_valid = 0;
  endtask

  task automatic epop(output logic v, output logic [31:0] d);
    @(negedge clk); v = eng_in_valid; d = eng_in_data; eng_in_ready = 1;
    @(negedge clk); eng_in_ready = 0;
  endtask

  // op: 0 host write, 1 host read, 2 engine push (exp=ready), 3 engine pop
  localparam int NV = 18;
  localparam logic [68:0] VEC [NV] = '{
    {2'd0, A_CTRL, 32'h0303_0000, 32'h0},           // enable all
    {2'd1, A_CTRL, 32'h0, 32'h0303_0000},           // R10
    {2'd1, A_STAT, 32'h0, 32'h0026_0000},           // R6 R7
    {2'd0, A_DATA, 32'h1111_1111, 32'h0},
    {2'd0, A_DATA, 32'h2222_2222, 32'h0},
    {2'd0, A_DATA, 32'h3333_3333, 32'h0},           // dropped R3
    {2'd1, A_STAT, 32'h0, 32'h000C_0000},           // R6
    {2'd3, A_DATA, 32'h0, 32'h1111_1111},           // R2
    {2'd3, A_DATA, 32'h0, 32'h2222_2222},           // R3
    {2'd1, A_STAT, 32'h0, 32'h0026_0000},           // R7
    {2'd2, A_DATA, 32'hAAAA_0001, 32'h1},           // R4
    {2'd2, A_DATA, 32'hAAAA_0002, 32'h1},
    {2'd2, A_DATA, 32'hAAAA_0003, 32'h0},           // full R4
    {2'd1, A_STAT, 32'h0, 32'h0063_0000},           // R6 R7
    {2'd1, A_DATA, 32'h0, 32'hAAAA_0001},           // R4
    {2'd1, A_DATA, 32'h0, 32'hAAAA_0002},
    {2'd1, A_DATA, 32'h0, 32'h0000_0000},           // R5
    {2'd1, A_STAT, 32'h0, 32'h0026_0000}            // R5
  };

  initial begin
    logic [31:0] d;
    logic r, v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    hread(A_STAT, d); chk("R1 status", d, 32'h0006_0000);
    hread(A_CTRL, d); chk("R1 control", d, 32'h0);
    hread(A_MBX, d);  chk("R1 mailbox", d, 32'h0);
    chk("R1 irq pins", {28'h0, irq_mbx, irq_in, irq_out, irq_wp}, 32'h0);
    chk("R1 in valid", {31'h0, eng_in_valid}, 32'h0);

    // R2 write ignored without inbound access
    hwrite(A_DATA, 32'hDEAD_0001);
    chk("R2 gated push", {31'h0, eng_in_valid}, 32'h0);
    // R4 engine push refused without outbound access
    epush(32'hBEEF_0001, r); chk("R4 gated ready", {31'h0, r}, 32'h0);
    hread(A_DATA, d); chk("R4 nothing queued", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [2:0] a; logic [31:0] wd, ex;
      {op, a, wd, ex} = VEC[i];
      case (op)
        2'd0: hwrite(a, wd);
        2'd1: begin hread(a, d); chk($sformatf("R6 vec %0d read", i), d, ex); end
        2'd2: begin epush(wd, r); chk($sformatf("R4 vec %0d ready", i), {31'h0, r}, ex); end
        default: begin
          epop(v, d);
          chk($sformatf("R2 vec %0d valid", i), {31'h0, v}, 32'h1);
          chk($sformatf("R2 vec %0d data", i), d, ex);
        end
      endcase
    end

    // R10 unused control bits
    hwrite(A_CTRL, 32'hFFFF_FFFF);
    hread(A_CTRL, d); chk("R10 masked", d, 32'h0303_0000);
    hwrite(A_CTRL, 32'h0300_0000);
    chk("R7 irq_in disabled", {31'h0, irq_in}, 32'h0);

    // R8 mailbox
    @(negedge clk); eng_mbx_wr = 1; eng_mbx_data = 32'h1234_5678;
    @(negedge clk); eng_mbx_wr = 0;
    chk("R8 irq_mbx set", {31'h0, irq_mbx}, 32'h1);
    hread(A_MBX, d); chk("R8 mailbox word", d, 32'h1234_5678);
    hread(A_STAT, d); chk("R8 status bit20", d, 32'h0016_0000);
    hwrite(A_MBX, 32'h0000_0005);
    hread(A_MBX, d); chk("R8 other value ignored", d, 32'h1234_5678);
    chk("R8 still pending", {31'h0, irq_mbx}, 32'h1);
    // same-cycle: engine wins
    @(negedge clk); host_wr = 1; host_addr = A_MBX; host_wdata = 32'h0000_F0F0;
    eng_mbx_wr = 1; eng_mbx_data = 32'h0000_0042;
    @(negedge clk); host_wr = 0; eng_mbx_wr = 0;
    hread(A_MBX, d); chk("R8 engine priority", d, 32'h0000_0042);
    hwrite(A_MBX, 32'h0000_F0F0);
    chk("R8 cleared irq", {31'h0, irq_mbx}, 32'h0);
    hread(A_MBX, d); chk("R8 cleared word", d, 32'h0);

    // R9 watch queue
    @(negedge clk); eng_wp_valid = 1; eng_wp_data = 31'h7000_0001;
    @(negedge clk); eng_wp_data = 31'h0000_0002;
    @(negedge clk); eng_wp_valid = 0;
    chk("R9 irq_wp", {31'h0, irq_wp}, 32'h1);
    hread(A_STAT, d); chk("R9 status bit23", d, 32'h0086_0000);
    hread(A_WATCH, d); chk("R9 first word", d, 32'hF000_0001);
    hread(A_WATCH, d); chk("R9 second word", d, 32'h8000_0002);
    hread(A_WATCH, d); chk("R9 empty read", d, 32'h0);
    chk("R9 irq_wp clear", {31'h0, irq_wp}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule